// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the command front end and protection gate of a small serial flash slave. It watches an SPI mode 0 link (data captured on rising SCK, driven on falling SCK), gathers the opcode and a 24-bit address from each chip-select frame, and decides at the end of the frame whether a page write, page program, page erase or sector erase may start. An accepted command produces a single-cycle start pulse with the command kind and address, and the block then reports itself busy for a parameterised number of clock cycles.

A command that changes stored data starts only when all of these hold: software has armed it with a write-enable command, the frame holds a whole number of bytes, the target page is outside the region guarded by the lock pin, the part is awake, the power-up hold-off has run out, and no earlier operation is in progress. A two-bit status byte (write-enable latch and busy flag) can be polled at any time, including while busy. The SPI pins are sampled through a synchronizer on the block clock `clk`.

Top module: `flash_wp_ctrl`

## Requirements
- R1: Opcode 05h returns the status byte MSB first on `miso`, one bit per falling SCK edge after the opcode, repeating every 8 bits; bit 1 is the write-enable latch, bit 0 is the busy flag, bits 7 to 2 read 0. Outside such a read `miso` is 0.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it, each taking effect when chip select rises.
- R3: A modify command (0Ah, 02h, DBh, D8h) with the write-enable latch clear starts nothing and leaves the status unchanged.
- R4: A modify command is discarded when the frame's SCK rising-edge count is not a multiple of 8 or is below 32 (opcode plus 24-bit address, MSB first).
- R5: With `lock_n` low, a modify command whose page, address bits [17:8] under the default 1024 pages, lies in the top 256 pages is rejected; with `lock_n` high the same command is accepted.
- R6: An accepted modify command pulses `op_start` for one cycle and sets the busy flag; after `BUSY_CYCLES` cycles the busy flag and the write-enable latch clear together.
- R7: While busy, every command other than 05h is ignored, so 04h does not clear the latch.
- R8: Opcode B9h enters deep power-down, where modify commands and status reads are ignored (`miso` stays 0); opcode ABh leaves it, and the latch keeps its value.
- R9: A low level on `rst_n` clears the latch, the busy flag and deep power-down, and holds `op_start` at 0.
- R10: For `PUW_CYCLES` cycles after `rst_n` rises, modify commands are rejected even with the latch set.
- R11: `op_kind` encodes 0 for 0Ah page write, 1 for 02h page program, 2 for DBh page erase, 3 for D8h sector erase; `op_addr` carries the frame's 24-bit address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| lock_n | input | 1 | Active-low lock of the top page region |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial status data to the host |
| op_start | output | 1 | One-cycle pulse starting an accepted operation |
| op_kind | output | 2 | Kind of the started operation |
| op_addr | output | 24 | Address of the started operation |

## Verification
The bound checker watches every cycle that a start pulse only occurs with the latch set, outside deep power-down, after the hold-off, and outside the locked pages when the lock pin was low; that the pulse lasts one cycle and coincides with the busy flag rising; and that the busy flag and latch fall together. Whether a command was rejected for a bad bit count, a clear latch or an active busy interval, what bits appear on `miso`, and that the latch survives a power-down round trip can only be shown by the bench's directed frames and status polls.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_WRDI = 8'h04;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_PW   = 8'h0A;
   localparam logic [7:0] OPC_PP   = 8'h02;
   localparam logic [7:0] OPC_PE   = 8'hDB;
   localparam logic [7:0] OPC_SE   = 8'hD8;
   localparam logic [7:0] OPC_DPD  = 8'hB9;
   localparam logic [7:0] OPC_WAKE = 8'hAB;

   typedef enum logic [1:0] {
      KIND_PW = 2'd0,
      KIND_PP = 2'd1,
      KIND_PE = 2'd2,
      KIND_SE = 2'd3
   } mod_kind_e;
endpackage

// File: rtl/flash_wp_spi_rx.sv
module flash_wp_spi_rx #(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_BYTES  = 3,
   localparam int AW         = 8 * ADDR_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sck,
   input  logic          cs_n,
   input  logic          mosi,
   input  logic [7:0]    status,
   input  logic          status_en,
   output logic          miso,
   output logic          frame_end,
   output logic [7:0]    opcode,
   output logic          opc_valid,
   output logic [AW-1:0] addr,
   output logic          addr_valid,
   output logic          whole
);
   localparam int HDR_BYTES = 1 + ADDR_BYTES;
   localparam int BCW       = $clog2(HDR_BYTES + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_BYTES < 2) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 2");
   end

   // stage bits: [2] sck, [1] cs_n, [0] mosi
   logic [2:0]     stage [SYNC_STAGES];
   logic           sck_d, cs_d;
   logic [6:0]     shreg;
   logic [2:0]     bit_lo;
   logic [BCW-1:0] byte_cnt;
   logic [2:0]     idx;

   wire sck_s  = stage[SYNC_STAGES-1][2];
   wire cs_s   = stage[SYNC_STAGES-1][1];
   wire mosi_s = stage[SYNC_STAGES-1][0];
   wire rise   = sck_s & ~sck_d & ~cs_s;
   wire fall   = ~sck_s & sck_d & ~cs_s;
   wire cs_fall = ~cs_s & cs_d;
   wire cs_rise = cs_s & ~cs_d;
   wire [7:0] nbyte = {shreg, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= 3'b010;
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         stage[0] <= {sck, cs_n, mosi};
         for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_end <= 1'b0;
         shreg     <= '0;
         bit_lo    <= '0;
         byte_cnt  <= '0;
         idx       <= 3'd7;
         miso      <= 1'b0;
         opcode    <= '0;
         addr      <= '0;
      end else begin
         frame_end <= cs_rise;
         if (cs_fall) begin
            shreg    <= '0;
            bit_lo   <= '0;
            byte_cnt <= '0;
            idx      <= 3'd7;
            miso     <= 1'b0;
         end else if (cs_s) begin
            miso <= 1'b0;
         end else begin
            if (rise) begin
               shreg  <= nbyte[6:0];
               bit_lo <= bit_lo + 3'd1;
               if (bit_lo == 3'd7 && byte_cnt != BCW'(HDR_BYTES)) begin
                  byte_cnt <= byte_cnt + BCW'(1);
                  if (byte_cnt == '0) opcode <= nbyte;
                  else                addr   <= {addr[AW-9:0], nbyte};
               end
            end
            if (fall) begin
               if (status_en) begin
                  miso <= status[idx];
                  idx  <= idx - 3'd1;
               end else begin
                  miso <= 1'b0;
               end
            end
         end
      end
   end

   assign opc_valid  = (byte_cnt != '0);
   assign addr_valid = (byte_cnt == BCW'(HDR_BYTES));
   assign whole      = (bit_lo == 3'd0);
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard #(
   parameter int BUSY_CYCLES = 4096,
   parameter int PUW_CYCLES  = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_wel,
   input  logic clr_wel,
   input  logic start_op,
   input  logic enter_dpd,
   input  logic exit_dpd,
   output logic wel,
   output logic wip,
   output logic dpd,
   output logic puw_done
);
   localparam int BW = $clog2(BUSY_CYCLES + 1);

   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   logic [BW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel      <= 1'b0;
         wip      <= 1'b0;
         dpd      <= 1'b0;
         busy_cnt <= '0;
      end else begin
         if (wip) begin
            if (busy_cnt == '0) begin
               wip <= 1'b0;
               wel <= 1'b0;
            end else begin
               busy_cnt <= busy_cnt - BW'(1);
            end
         end else if (start_op) begin
            wip      <= 1'b1;
            busy_cnt <= BW'(BUSY_CYCLES - 1);
         end else if (set_wel) begin
            wel <= 1'b1;
         end else if (clr_wel) begin
            wel <= 1'b0;
         end
         if (enter_dpd)     dpd <= 1'b1;
         else if (exit_dpd) dpd <= 1'b0;
      end
   end

   if (PUW_CYCLES == 0) begin : g_no_puw
      assign puw_done = 1'b1;
   end else begin : g_puw
      localparam int PW = $clog2(PUW_CYCLES + 1);
      logic [PW-1:0] puw_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          puw_cnt <= '0;
         else if (puw_cnt != PW'(PUW_CYCLES)) puw_cnt <= puw_cnt + PW'(1);
      end
      assign puw_done = (puw_cnt == PW'(PUW_CYCLES));
   end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
   parameter int NUM_PAGES   = 1024,
   parameter int LOCK_PAGES  = 256,
   parameter int ADDR_BYTES  = 3,
   parameter int BUSY_CYCLES = 4096,
   parameter int PUW_CYCLES  = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lock_n,
   input  logic                    sck,
   input  logic                    cs_n,
   input  logic                    mosi,
   output logic                    miso,
   output logic                    op_start,
   output logic [1:0]              op_kind,
   output logic [8*ADDR_BYTES-1:0] op_addr
);
   import flash_wp_pkg::*;

   localparam int AW     = 8 * ADDR_BYTES;
   localparam int PAGE_W = $clog2(NUM_PAGES);
   localparam logic [PAGE_W:0] LOCK_BASE = (PAGE_W+1)'(NUM_PAGES - LOCK_PAGES);

   if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two");
   end
   if (LOCK_PAGES < 0 || LOCK_PAGES > NUM_PAGES) begin : g_bad_lock
      $error("LOCK_PAGES must lie within NUM_PAGES");
   end
   if (8 + PAGE_W > AW) begin : g_bad_span
      $error("address too narrow for NUM_PAGES");
   end

   logic          frame_end, opc_valid, addr_valid, whole;
   logic [7:0]    opcode;
   logic [AW-1:0] addr;
   logic          wel_q, wip_q, dpd_q, puw_done;
   logic          is_mod, locked, go, accept;
   logic          set_wel, clr_wel, enter_dpd, exit_dpd, status_en;
   mod_kind_e     kind;

   always_comb begin
      is_mod = 1'b1;
      kind   = KIND_PP;
      unique case (opcode)
         OPC_PW:  kind = KIND_PW;
         OPC_PP:  kind = KIND_PP;
         OPC_PE:  kind = KIND_PE;
         OPC_SE:  kind = KIND_SE;
         default: is_mod = 1'b0;
      endcase
   end

   assign locked    = !lock_n && ({1'b0, addr[8 +: PAGE_W]} >= LOCK_BASE);
   assign go        = frame_end && !wip_q && opc_valid;
   assign set_wel   = go && !dpd_q && opcode == OPC_WREN;
   assign clr_wel   = go && !dpd_q && opcode == OPC_WRDI;
   assign enter_dpd = go && !dpd_q && opcode == OPC_DPD;
   assign exit_dpd  = go && dpd_q && opcode == OPC_WAKE;
   assign accept    = go && !dpd_q && is_mod && addr_valid && whole
                      && wel_q && puw_done && !locked;
   assign status_en = opc_valid && opcode == OPC_RDSR && !dpd_q;

   flash_wp_spi_rx #(
      .SYNC_STAGES(SYNC_STAGES),
      .ADDR_BYTES (ADDR_BYTES)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck       (sck),
      .cs_n      (cs_n),
      .mosi      (mosi),
      .status    ({6'b0, wel_q, wip_q}),
      .status_en (status_en),
      .miso      (miso),
      .frame_end (frame_end),
      .opcode    (opcode),
      .opc_valid (opc_valid),
      .addr      (addr),
      .addr_valid(addr_valid),
      .whole     (whole)
   );

   flash_wp_guard #(
      .BUSY_CYCLES(BUSY_CYCLES),
      .PUW_CYCLES (PUW_CYCLES)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_wel  (set_wel),
      .clr_wel  (clr_wel),
      .start_op (accept),
      .enter_dpd(enter_dpd),
      .exit_dpd (exit_dpd),
      .wel      (wel_q),
      .wip      (wip_q),
      .dpd      (dpd_q),
      .puw_done (puw_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_start <= 1'b0;
         op_kind  <= '0;
         op_addr  <= '0;
      end else begin
         op_start <= accept;
         if (accept) begin
            op_kind <= kind;
            op_addr <= addr;
         end
      end
   end
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk #(
   parameter int NUM_PAGES  = 1024,
   parameter int LOCK_PAGES = 256,
   parameter int AW         = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lock_n,
   input logic          op_start,
   input logic [AW-1:0] op_addr,
   input logic          wel_q,
   input logic          wip_q,
   input logic          dpd_q,
   input logic          puw_done
);
   localparam int PAGE_W = $clog2(NUM_PAGES);
   localparam logic [PAGE_W:0] LOCK_BASE = (PAGE_W+1)'(NUM_PAGES - LOCK_PAGES);

   // R3: a start needs the armed latch
   p_start_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> wel_q && wip_q);

   // R6: start is a single-cycle pulse
   p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> !op_start);

   // R6: busy only rises together with a start
   p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip_q) |-> op_start);

   // R6: latch and busy clear in the same cycle
   p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip_q) |-> $fell(wel_q));

   // R7: latch stays set for the whole busy interval
   p_busy_holds_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wip_q |-> wel_q);

   // R5: no start inside the locked region while the pin was low
   p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !$past(lock_n)) |-> ({1'b0, op_addr[8 +: PAGE_W]} < LOCK_BASE));

   // R8: no start decided during deep power-down
   p_dpd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> !$past(dpd_q));

   // R10: no start before the hold-off ends
   p_puw_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> $past(puw_done));
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(
   .NUM_PAGES (NUM_PAGES),
   .LOCK_PAGES(LOCK_PAGES),
   .AW        (8 * ADDR_BYTES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lock_n  (lock_n),
   .op_start(op_start),
   .op_addr (op_addr),
   .wel_q   (wel_q),
   .wip_q   (wip_q),
   .dpd_q   (dpd_q),
   .puw_done(puw_done)
);

// File: tb/flash_wp_ctrl_bench.sv
module flash_wp_ctrl_bench;
   localparam int PUW  = 1000;
   localparam int BUSY = 1500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lock_n = 1'b1;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        miso;
   logic        op_start;
   logic [1:0]  op_kind;
   logic [23:0] op_addr;

   int checks = 0;
   int errors = 0;
   int starts = 0;
   logic [1:0]  last_kind = '0;
   logic [23:0] last_addr = '0;

   always #4 clk = ~clk;

   flash_wp_ctrl #(
      .BUSY_CYCLES(BUSY),
      .PUW_CYCLES (PUW)
   ) u_flash_wp_ctrl (
      .clk(clk), .rst_n(rst_n), .lock_n(lock_n), .sck(sck), .cs_n(cs_n),
      .mosi(mosi), .miso(miso), .op_start(op_start), .op_kind(op_kind),
      .op_addr(op_addr)
   );

   always @(negedge clk) begin
      if (op_start) begin
         starts    <= starts + 1;
         last_kind <= op_kind;
         last_addr <= op_addr;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [63:0] data, input int nbits, output logic [63:0] rx);
      rx = '0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = data[63-i];
         repeat (6) @(negedge clk);
         rx[63-i] = miso;
         sck = 1'b1;
         repeat (6) @(negedge clk);
         sck = 1'b0;
      end
      repeat (6) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] opc);
      logic [63:0] rx;
      xfer({opc, 56'h0}, 8, rx);
   endtask

   task automatic modify(input logic [7:0] opc, input logic [23:0] a, input int nbits);
      logic [63:0] rx;
      xfer({opc, a, 32'h0}, nbits, rx);
   endtask

   task automatic read_status(output logic [7:0] st);
      logic [63:0] rx;
      xfer({8'h05, 56'h0}, 16, rx);
      st = rx[55:48];
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_powerup();
      logic [7:0] st;
      int s0;
      do_reset();
      chk("R9 miso at reset", miso, 0);
      chk("R9 op_start at reset", op_start, 0);
      s0 = starts;
      cmd(8'h06);
      modify(8'h02, 24'h000100, 32);
      chk("R10 no start during hold-off", starts - s0, 0);
      read_status(st);
      chk("R2 latch set by 06h", st, 8'h02);
      repeat (PUW) @(negedge clk);
   endtask

   task automatic t_program_busy();
      logic [7:0]  st;
      logic [63:0] rx;
      int s0;
      s0 = starts;
      modify(8'h02, 24'h000100, 32);
      chk("R6 start pulse count", starts - s0, 1);
      chk("R11 kind page program", last_kind, 1);
      chk("R11 address", last_addr, 24'h000100);
      xfer({8'h05, 56'h0}, 24, rx);
      chk("R1 status while busy", rx[55:48], 8'h03);
      chk("R1 status repeats", rx[47:40], 8'h03);
      cmd(8'h04);
      read_status(st);
      chk("R7 04h ignored while busy", st, 8'h03);
      repeat (BUSY + 100) @(negedge clk);
      read_status(st);
      chk("R6 busy and latch cleared", st, 8'h00);
   endtask

   task automatic t_no_latch();
      logic [7:0] st;
      int s0;
      s0 = starts;
      modify(8'hDB, 24'h000200, 32);
      chk("R3 no start without latch", starts - s0, 0);
      read_status(st);
      chk("R3 status unchanged", st, 8'h00);
   endtask

   task automatic t_bitcount();
      logic [7:0] st;
      int s0;
      cmd(8'h06);
      s0 = starts;
      modify(8'hD8, 24'h000000, 33);
      chk("R4 33-bit frame discarded", starts - s0, 0);
      modify(8'h0A, 24'h000000, 16);
      chk("R4 short frame discarded", starts - s0, 0);
      read_status(st);
      chk("R4 latch still set", st, 8'h02);
      modify(8'hD8, 24'h001000, 32);
      chk("R4 whole frame accepted", starts - s0, 1);
      chk("R11 kind sector erase", last_kind, 3);
      repeat (BUSY + 100) @(negedge clk);
   endtask

   task automatic t_lock();
      logic [7:0] st;
      int s0;
      lock_n = 1'b0;
      cmd(8'h06);
      s0 = starts;
      modify(8'h0A, 24'h03FF00, 32);
      chk("R5 top page locked", starts - s0, 0);
      read_status(st);
      chk("R5 status after reject", st, 8'h02);
      modify(8'h0A, 24'h02FF00, 32);
      chk("R5 page below region accepted", starts - s0, 1);
      chk("R11 kind page write", last_kind, 0);
      repeat (BUSY + 100) @(negedge clk);
      lock_n = 1'b1;
      cmd(8'h06);
      modify(8'hDB, 24'h030000, 32);
      chk("R5 unlocked top page accepted", starts - s0, 2);
      chk("R11 kind page erase", last_kind, 2);
      chk("R11 erase address", last_addr, 24'h030000);
      repeat (BUSY + 100) @(negedge clk);
   endtask

   task automatic t_powerdown();
      logic [7:0] st;
      int s0;
      cmd(8'h06);
      cmd(8'hB9);
      read_status(st);
      chk("R8 status read ignored", st, 8'h00);
      s0 = starts;
      modify(8'h02, 24'h000300, 32);
      chk("R8 modify ignored", starts - s0, 0);
      cmd(8'hAB);
      read_status(st);
      chk("R8 latch kept after wake", st, 8'h02);
      cmd(8'h04);
      read_status(st);
      chk("R2 latch cleared by 04h", st, 8'h00);
   endtask

   task automatic t_reset_pin();
      logic [7:0] st;
      int s0;
      cmd(8'h06);
      cmd(8'hB9);
      do_reset();
      read_status(st);
      chk("R9 reset clears latch and power-down", st, 8'h00);
      s0 = starts;
      cmd(8'h06);
      modify(8'h02, 24'h000100, 32);
      chk("R10 hold-off restarts after reset", starts - s0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_powerup();
      t_program_busy();
      t_no_latch();
      t_bitcount();
      t_lock();
      t_powerdown();
      t_reset_pin();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule